// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a word-addressed processor port and a slower main-memory port. It keeps one data word per line in a small register array. The line is picked by the low-order bits of the word address. The remaining upper bits are held as the line's tag, and one comparator checks that tag against the request. A read that finds its word is answered in the cycle it is accepted and makes no memory access. A read that misses stalls the processor port, fetches the word over the memory port and fills the line. The fetched word is handed to the processor in the cycle the memory acknowledges.

Every write goes through to memory, and the processor port stalls until memory acknowledges it. The same write also installs its tag and data in the addressed line, whether the lookup hit or missed. Two addresses that share their low bits compete for one line and push each other out. A pair of single-cycle pulses, one for a hit and one for a miss, marks the outcome of each accepted request, so that the hit ratio can be counted outside the block.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset the processor port is ready, no memory request is pending, and every line is invalid, so the first read of any address is a miss.
- R2: The line index is `cpu_addr[IDX_W-1:0]` and the tag is `cpu_addr[ADDR_W-1:IDX_W]`. A lookup hits only when the indexed line is valid and its stored tag equals the request tag.
- R3: A read hit asserts `cpu_rvalid` and returns the stored word on `cpu_rdata` in the cycle the request is accepted. It issues no memory request, and the port is ready again in the next cycle.
- R4: On a read miss, `mem_req` rises with `mem_we`=0 and `mem_addr` equal to the request address in the cycle after acceptance. In the cycle `mem_ack` is high, `cpu_rvalid` is asserted with `cpu_rdata` equal to `mem_rdata`, and the line is filled so that a following read of that address hits.
- R5: On a write hit, the line's word is replaced by the written data, and a memory write of the same address and data is issued from the next cycle.
- R6: On a write miss, a memory write of the address and data is issued from the next cycle. The line takes the new tag and data, so a following read of that address hits and returns the written word.
- R7: `cpu_ready` is low from the cycle after a miss or write is accepted through the cycle of `mem_ack`, and it is high again in the cycle after `mem_ack`.
- R8: While `mem_req` is high and `mem_ack` has not yet arrived, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R9: Reads that alternate between two addresses with equal index and different tags each miss, and each one returns that address's memory contents.
- R10: Each accepted request raises exactly one of `hit_pulse` and `miss_pulse` for that one cycle. Neither is raised in a cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Cache can accept a request this cycle |
| cpu_rvalid | output | 1 | Read data valid this cycle |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle completion strobe from memory |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| hit_pulse | output | 1 | Accepted request hit |
| miss_pulse | output | 1 | Accepted request missed |

## Verification
A hit's data and its hit or miss pulse are due in the same cycle the request is accepted. A memory request is due one cycle after acceptance, and a miss's read data is due in the very cycle the acknowledge is driven. The port's readiness returns one cycle after the acknowledge. The bench drives every input just after a falling edge and samples two nanoseconds later, before the next rising edge, so each of these results is compared in the cycle it is due. A behavioural model of tags, valid bits and memory contents predicts each hit or miss, and the memory latency is varied from one to three cycles to show that the request stays stable until the acknowledge.

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              hit_pulse,
  output logic              miss_pulse
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t               st;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              lookup_hit, accept, rd_done;
  logic              fill_en;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_data;

  assign idx        = cpu_addr[IDX_W-1:0];
  assign tag        = cpu_addr[ADDR_W-1:IDX_W];
  assign lookup_hit = valid_q[idx] && (tag_q[idx] == tag);
  assign cpu_ready  = (st == S_IDLE);
  assign accept     = cpu_req && cpu_ready;
  assign rd_done    = (st == S_RD) && mem_ack;

  assign hit_pulse  = accept && lookup_hit;
  assign miss_pulse = accept && !lookup_hit;

  assign cpu_rvalid = (accept && !cpu_we && lookup_hit) || rd_done;
  assign cpu_rdata  = (st == S_RD) ? mem_rdata : data_q[idx];

  assign mem_req    = (st != S_IDLE);
  assign mem_we     = (st == S_WR);
  assign mem_addr   = pend_addr;
  assign mem_wdata  = pend_data;

  assign fill_en    = (accept && cpu_we) || rd_done;
  assign fill_idx   = (st == S_RD) ? pend_addr[IDX_W-1:0] : idx;
  assign fill_tag   = (st == S_RD) ? pend_addr[ADDR_W-1:IDX_W] : tag;
  assign fill_data  = (st == S_RD) ? mem_rdata : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (accept && (cpu_we || !lookup_hit)) begin
          st        <= cpu_we ? S_WR : S_RD;
          pend_addr <= cpu_addr;
          pend_data <= cpu_wdata;
        end
        S_RD, S_WR: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_data;
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  p_ready_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> cpu_ready && !mem_req);

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_pulse, miss_pulse}));

  p_pulse_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pulse || miss_pulse) |-> cpu_req && cpu_ready);

  p_read_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse && !cpu_we |=> !mem_req);

  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse && !cpu_we |=> mem_req && !mem_we && mem_addr == $past(cpu_addr));

  p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ready && cpu_we |=> mem_req && mem_we && mem_wdata == $past(cpu_wdata));
endmodule

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
  localparam int AW = 12, DW = 16, IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          hit_pulse, miss_pulse;

  int vectors = 0, miscompares = 0, hits = 0, misses = 0;
  bit done = 0;

  logic [DW-1:0] refmem [int];
  bit            mvalid [16];
  int            mtag   [16];

  always #5 clk = ~clk;

  dm_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse));

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    if (refmem.exists(int'(a))) return refmem[int'(a)];
    return DW'(a) ^ 16'h5a5a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input int lat);
    int  ix = int'(a[IW-1:0]);
    int  tg = int'(a[AW-1:IW]);
    bit  exp_hit = mvalid[ix] && (mtag[ix] == tg);
    logic [DW-1:0] exp_rd = memval(a);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #2;
    chk(cpu_ready == 1'b1, "R7 ready before request", cpu_ready, 1);
    chk(hit_pulse == exp_hit, "R2 R10 hit pulse", hit_pulse, exp_hit);
    chk(miss_pulse == !exp_hit, "R10 miss pulse", miss_pulse, !exp_hit);
    if (exp_hit) hits++; else misses++;
    if (!we && exp_hit) begin
      chk(cpu_rvalid == 1'b1, "R3 rvalid on hit", cpu_rvalid, 1);
      chk(cpu_rdata == exp_rd, "R3 hit data", cpu_rdata, exp_rd);
      @(negedge clk);
      cpu_req = 1'b0;
      #2;
      chk(mem_req == 1'b0, "R3 no memory access on hit", mem_req, 0);
      chk(cpu_ready == 1'b1, "R3 ready after hit", cpu_ready, 1);
      chk(hit_pulse == 1'b0 && miss_pulse == 1'b0, "R10 no pulse when idle", {hit_pulse, miss_pulse}, 0);
    end else begin
      chk(cpu_rvalid == 1'b0, "R4 no rvalid at accept", cpu_rvalid, 0);
      @(negedge clk);
      cpu_req = 1'b0;
      #2;
      chk(mem_req == 1'b1, we ? "R5 R6 write issued" : "R4 fetch issued", mem_req, 1);
      chk(mem_we == we, "R4 R5 mem_we", mem_we, we);
      chk(mem_addr == a, "R4 R6 mem_addr", mem_addr, a);
      if (we) chk(mem_wdata == wd, "R5 R6 mem_wdata", mem_wdata, wd);
      chk(cpu_ready == 1'b0, "R7 stalled", cpu_ready, 0);
      chk(hit_pulse == 1'b0 && miss_pulse == 1'b0, "R10 no pulse while stalled", {hit_pulse, miss_pulse}, 0);
      for (int k = 1; k < lat; k++) begin
        @(negedge clk); #2;
        chk(mem_req == 1'b1 && mem_addr == a && mem_we == we, "R8 request held", {mem_req, mem_we, mem_addr}, {1'b1, we, a});
        chk(cpu_ready == 1'b0, "R7 stalled while waiting", cpu_ready, 0);
      end
      @(negedge clk);
      mem_ack = 1'b1;
      mem_rdata = exp_rd;
      #2;
      chk(cpu_ready == 1'b0, "R7 not ready in ack cycle", cpu_ready, 0);
      if (!we) begin
        chk(cpu_rvalid == 1'b1, "R4 rvalid with ack", cpu_rvalid, 1);
        chk(cpu_rdata == exp_rd, "R4 R9 fetched data", cpu_rdata, exp_rd);
      end else begin
        chk(cpu_rvalid == 1'b0, "R5 no rvalid on write", cpu_rvalid, 0);
      end
      @(negedge clk);
      mem_ack = 1'b0;
      mem_rdata = '0;
      #2;
      chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R7 ready after ack", {cpu_ready, mem_req}, 2'b10);
    end
    if (we) refmem[int'(a)] = wd;
    mvalid[ix] = 1'b1;
    mtag[ix]   = tg;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mvalid[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(cpu_ready == 1'b1, "R1 ready after reset", cpu_ready, 1);
    chk(mem_req == 1'b0, "R1 no memory request after reset", mem_req, 0);
    chk(hit_pulse == 1'b0 && miss_pulse == 1'b0, "R10 idle after reset", {hit_pulse, miss_pulse}, 0);

    access(0, 12'h010, '0, 1);      // R1 cold miss
    access(0, 12'h010, '0, 1);      // R3 hit
    access(1, 12'h010, 16'hbeef, 2); // R5 write hit
    access(0, 12'h010, '0, 1);      // R5 updated data
    access(1, 12'h123, 16'h1234, 3); // R6 write miss allocates
    access(0, 12'h123, '0, 1);      // R6 read hits written word
    for (int k = 0; k < 3; k++) begin  // R9 thrashing pair
      access(0, 12'h005, '0, 2);
      access(0, 12'h105, '0, 1);
    end
    access(0, 12'h006, '0, 1);      // R2 different index
    access(0, 12'h105, '0, 1);      // R2 still resident
    begin
      int seed = 7;
      for (int n = 0; n < 300; n++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        access(seed[20], AW'({seed[9:8], 4'h0, seed[3:0]}) | AW'({seed[11:10], 8'h00}),
               DW'(seed >> 5), 1 + (seed[14:13] % 3));
      end
    end
    $display("hits %0d misses %0d", hits, misses);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule